// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital serial side of a telephony PCM codec. Once per frame it moves one 8-bit companded sample in each direction. On the transmit side, the converter writes a parallel code into a holding register. The code is then shifted out, most significant (sign) bit first, on a data pin that can go high-impedance. A transmit frame-sync pulse starts the shift, and the transmit bit clock paces it. On the receive side, a receive frame-sync pulse starts the capture. Eight serial bits are then sampled on falling bit-clock edges and handed over as a parallel byte with a one-cycle strobe. Frames normally repeat every 125 us.

All pin signals are sampled into one fast system clock through two-stage synchronizers, and edges are detected there. A mode input selects the receive bit clock. In shared-clock mode the receiver is paced by the transmit bit clock. In split-clock mode it uses its own receive bit clock. Frame-sync pulses may be short (one bit period) or long (several bit periods). Outside logic uses the output-enable signal to drive the tri-state pad.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held, `tx_oe`, `tx_slot`, `tx_dout` and `rx_valid` are all 0.
- R2: A rising edge on `tx_fsync` raises `tx_oe`, and `tx_dout` then carries bit 7 (the sign bit) of the code in the holding register.
- R3: The rising edges of `tx_bclk` that follow the frame-sync rise present bits 6 down to 0 in turn. The `tx_bclk` rise that occurs at or just before the frame-sync rise counts as the first of eight. `tx_dout` changes only on a bit-clock rise or a frame-sync rise.
- R4: With a short frame sync, `tx_oe` falls after the falling `tx_bclk` edge that follows the eighth rising edge.
- R5: While `tx_fsync` stays high, `tx_oe` stays high. With a long frame sync, `tx_oe` falls only after `tx_fsync` goes low.
- R6: A code written with `tx_load` goes into the holding register and is sent at the next frame-sync rise. A write during a frame does not alter the bits still being sent.
- R7: A `tx_fsync` rise during a frame restarts the shift with bit 7 of the current holding register.
- R8: After a `rx_fsync` rise, the next eight falling edges of the selected receive bit clock sample `rx_data`, first bit into bit 7. The byte then appears on `rx_code`, and `rx_valid` is high for exactly one cycle.
- R9: A `rx_fsync` rise before eight bits have been sampled drops the partial word without a strobe and restarts the count.
- R10: When `sync_mode` is 1, the receiver uses `tx_bclk` and `rx_bclk` has no effect.
- R11: When `sync_mode` is 0, the receiver uses `rx_bclk` and `tx_bclk` has no effect on it.
- R12: `tx_slot` equals `tx_oe`, and `tx_dout` is 0 whenever `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: receiver paced by tx_bclk; 0: by rx_bclk |
| tx_bclk | input | 1 | Transmit bit clock pin |
| tx_fsync | input | 1 | Transmit frame-sync pin |
| tx_load | input | 1 | Write strobe for the transmit holding register |
| tx_code | input | 8 | Code to be written into the holding register |
| tx_dout | output | 1 | Serial transmit data, valid while tx_oe is high |
| tx_oe | output | 1 | Output enable for the tri-state data pad |
| tx_slot | output | 1 | Transmit time-slot indicator |
| rx_bclk | input | 1 | Receive bit clock pin (split-clock mode) |
| rx_fsync | input | 1 | Receive frame-sync pin |
| rx_data | input | 1 | Serial receive data pin |
| rx_code | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_code |

## Verification
The bench builds the block with its defaults: 8-bit words and two synchronizer stages. It runs a 100 MHz system clock against a 160 ns transmit bit clock and a 220 ns receive bit clock. Because the two bit clocks are unrelated, a receiver that takes the wrong clock in either mode shows up. With these settings an edge reaches the logic about three system cycles after the pin, which is well inside one bit period. This lets the bench check the exact bit at every falling edge and the enable release within the half period that follows the last bit.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  // Transmit slot sequencing
  typedef enum logic [1:0] {
    TXS_IDLE  = 2'd0,  // pad released
    TXS_SHIFT = 2'd1,  // launching bits on bit-clock rises
    TXS_TAIL  = 2'd2,  // last bit out, waiting for its falling edge
    TXS_HOLD  = 2'd3   // bits done, waiting for frame sync low
  } tx_state_e;

  // Lanes of the shared pin synchronizer
  localparam int PIN_TXCLK = 0;
  localparam int PIN_TXFS  = 1;
  localparam int PIN_RXCLK = 2;
  localparam int PIN_RXFS  = 3;
  localparam int PIN_RXDAT = 4;
  localparam int PIN_COUNT = 5;

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign level = stage_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_slot_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] code,
  input  logic              fs_level,
  input  logic              fs_rise,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  output logic              dout,
  output logic              oe
);

  localparam int              CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_ADV = CNT_W'(WORD_W - 2);

  tx_state_e         state_q, state_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    hold_d  = load ? code : hold_q;
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (fs_rise) begin
      shreg_d = hold_q;
      cnt_d   = '0;
      state_d = TXS_SHIFT;
    end else begin
      case (state_q)
        TXS_SHIFT: begin
          if (bclk_rise) begin
            shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
            if (cnt_q == LAST_ADV) state_d = TXS_TAIL;
            else                   cnt_d   = cnt_q + 1'b1;
          end
        end
        TXS_TAIL: begin
          if (bclk_fall) state_d = TXS_HOLD;
        end
        TXS_HOLD: begin
          if (!fs_level) state_d = TXS_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      hold_q  <= '0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign oe   = (state_q != TXS_IDLE);
  assign dout = oe & shreg_q[WORD_W-1];

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_rise,
  input  logic              bclk_fall,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              valid
);

  localparam int              CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    if (fs_rise) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && bclk_fall) begin
      shreg_d = {shreg_q[WORD_W-2:0], din};
      if (cnt_q == LAST_BIT) begin
        word_d   = shreg_d;
        valid_d  = 1'b1;
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      shreg_q  <= shreg_d;
      word_q   <= word_d;
      valid_q  <= valid_d;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_code,
  output logic              tx_dout,
  output logic              tx_oe,
  output logic              tx_slot,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_data,
  output logic [WORD_W-1:0] rx_code,
  output logic              rx_valid
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Pin sampling
  logic [PIN_COUNT-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic [7:0]           sync_unused;

  always_comb begin
    pin_raw            = '0;
    pin_raw[PIN_TXCLK] = tx_bclk;
    pin_raw[PIN_TXFS]  = tx_fsync;
    pin_raw[PIN_RXCLK] = rx_bclk;
    pin_raw[PIN_RXFS]  = rx_fsync;
    pin_raw[PIN_RXDAT] = rx_data;
  end

  pcm_pin_sync #(
    .WIDTH (PIN_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .pin  (pin_raw),
    .level(pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign sync_unused = {pin_lvl[PIN_TXCLK], pin_lvl[PIN_RXCLK], pin_lvl[PIN_RXFS],
                        pin_rise[PIN_RXCLK], pin_rise[PIN_RXDAT], pin_fall[PIN_TXFS],
                        pin_fall[PIN_RXFS], pin_fall[PIN_RXDAT]};

  logic tx_fs_lvl, tx_fs_rise, tx_bclk_rise, tx_bclk_fall, rx_bit_fall;

  assign tx_fs_lvl    = pin_lvl[PIN_TXFS];
  assign tx_fs_rise   = pin_rise[PIN_TXFS];
  assign tx_bclk_rise = pin_rise[PIN_TXCLK];
  assign tx_bclk_fall = pin_fall[PIN_TXCLK];
  assign rx_bit_fall  = sync_mode ? pin_fall[PIN_TXCLK] : pin_fall[PIN_RXCLK];

  pcm_tx_slot #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tx_load),
    .code     (tx_code),
    .fs_level (tx_fs_lvl),
    .fs_rise  (tx_fs_rise),
    .bclk_rise(tx_bclk_rise),
    .bclk_fall(tx_bclk_fall),
    .dout     (tx_dout),
    .oe       (tx_oe)
  );

  assign tx_slot = tx_oe;

  pcm_rx_slot #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fs_rise  (pin_rise[PIN_RXFS]),
    .bclk_fall(rx_bit_fall),
    .din      (pin_lvl[PIN_RXDAT]),
    .word     (rx_code),
    .valid    (rx_valid)
  );

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_oe,
  input logic tx_slot,
  input logic tx_dout,
  input logic rx_valid,
  input logic tx_fs_lvl,
  input logic tx_fs_rise,
  input logic tx_bclk_rise,
  input logic rx_bit_fall
);

  a_r2_enable_follows_fs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(tx_fs_rise));

  a_r5_enable_held_by_fs: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && tx_fs_lvl) |=> tx_oe);

  a_r3_data_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && !tx_bclk_rise && !tx_fs_rise) |=> (!tx_oe || $stable(tx_dout)));

  a_r12_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> (!tx_dout && !tx_slot));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_bit_fall));

endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_oe       (tx_oe),
  .tx_slot     (tx_slot),
  .tx_dout     (tx_dout),
  .rx_valid    (rx_valid),
  .tx_fs_lvl   (tx_fs_lvl),
  .tx_fs_rise  (tx_fs_rise),
  .tx_bclk_rise(tx_bclk_rise),
  .rx_bit_fall (rx_bit_fall)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

  logic       clk, rst_n, sync_mode;
  logic       tx_bclk, tx_fsync, tx_load;
  logic [7:0] tx_code;
  logic       tx_dout, tx_oe, tx_slot;
  logic       rx_bclk, rx_fsync, rx_data;
  logic [7:0] rx_code;
  logic       rx_valid;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rxq[$];

  pcm_slot_port uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_load(tx_load), .tx_code(tx_code),
    .tx_dout(tx_dout), .tx_oe(tx_oe), .tx_slot(tx_slot),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_data(rx_data),
    .rx_code(rx_code), .rx_valid(rx_valid)
  );

  initial begin clk = 1'b0;     forever #5   clk = ~clk; end
  initial begin tx_bclk = 1'b0; forever #80  tx_bclk = ~tx_bclk; end
  initial begin rx_bclk = 1'b0; forever #110 rx_bclk = ~rx_bclk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_code(input logic [7:0] v);
    @(negedge clk); tx_code = v; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  // Transmit frame: raise sync, check each bit at the falling edge, then the release
  task automatic tx_frame(input logic [7:0] code, input int fs_periods, input string tag);
    @(posedge tx_bclk); #1 tx_fsync = 1'b1;
    fork
      begin
        repeat (fs_periods) @(posedge tx_bclk);
        #1 tx_fsync = 1'b0;
      end
    join_none
    for (int i = 0; i < 8; i++) begin
      @(negedge tx_bclk); #1;
      chk((i == 0) ? "R2" : tag, {31'd0, tx_oe, tx_dout}, {31'd0, 1'b1, code[7-i]});
    end
    #50;
    if (fs_periods <= 8) begin
      chk("R4", {31'd0, tx_oe}, 32'd0);
    end else begin
      chk("R5", {31'd0, tx_oe}, 32'd1);
      wait (tx_fsync == 1'b0);
      @(negedge tx_bclk); #1;
      chk("R5", {31'd0, tx_oe}, 32'd0);
    end
    chk("R12", {30'd0, tx_slot, tx_dout}, 32'd0);
  endtask

  task automatic rx_edge(input bit on_tx);
    if (on_tx) @(posedge tx_bclk);
    else       @(posedge rx_bclk);
  endtask

  // Receive frame: drive nbits of code, MSB first, changing data on rising edges
  task automatic rx_frame(input logic [7:0] code, input int nbits, input bit on_tx);
    rx_edge(on_tx); #1 rx_fsync = 1'b1; rx_data = code[7];
    for (int i = 1; i < nbits; i++) begin
      rx_edge(on_tx); #1;
      rx_fsync = 1'b0;
      rx_data  = code[7-i];
    end
    rx_edge(on_tx); #1 rx_fsync = 1'b0;
    if (on_tx) @(negedge tx_bclk);
    else       @(negedge rx_bclk);
    #60;
  endtask

  // Scoreboard monitor for received bytes
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: actual unexpected byte %0h expected no strobe", rx_code);
      end else begin
        logic [7:0] exp_b;
        exp_b = rxq.pop_front();
        chk("R8", {24'd0, rx_code}, {24'd0, exp_b});
      end
    end
  end

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_mode = 1'b0; tx_fsync = 1'b0; tx_load = 1'b0;
    tx_code = 8'h00; rx_fsync = 1'b0; rx_data = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", {28'd0, tx_oe, tx_slot, tx_dout, rx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", {29'd0, tx_oe, tx_dout, rx_valid}, 32'd0);

    // Short frame sync
    load_code(8'hC3);
    tx_frame(8'hC3, 1, "R3");

    // Long frame sync, boundary pattern
    load_code(8'h81);
    tx_frame(8'h81, 12, "R3");

    // Mid-frame load does not disturb; re-raised sync restarts with new code
    load_code(8'hE4);
    @(posedge tx_bclk); #1 tx_fsync = 1'b1;
    @(negedge tx_bclk); #1;
    chk("R2", {31'd0, tx_oe, tx_dout}, {31'd0, 1'b1, 1'b1});
    load_code(8'h1B);
    @(posedge tx_bclk); #1 tx_fsync = 1'b0;
    @(negedge tx_bclk); #1;
    chk("R6", {31'd0, tx_dout}, 32'd1);
    @(negedge tx_bclk); #1;
    chk("R6", {31'd0, tx_dout}, 32'd1);
    tx_frame(8'h1B, 1, "R7");

    // Receive, split-clock mode
    sync_mode = 1'b0;
    rxq.push_back(8'hA5);
    rx_frame(8'hA5, 8, 1'b0);
    chk("R11", {31'd0, rx_valid}, 32'd0);
    rx_frame(8'hFF, 4, 1'b0);               // R9: partial word dropped
    chk("R9", rxq.size(), 32'd0);
    rxq.push_back(8'h3C);
    rx_frame(8'h3C, 8, 1'b0);
    rxq.push_back(8'h01);
    rx_frame(8'h01, 8, 1'b0);

    // Receive, shared-clock mode (rx_bclk keeps running, must be ignored)
    sync_mode = 1'b1;
    rxq.push_back(8'h96);
    rx_frame(8'h96, 8, 1'b1);                // R10
    rxq.push_back(8'h7E);
    rx_frame(8'h7E, 8, 1'b1);                // R10

    repeat (20) @(negedge clk);
    chk("R10", rxq.size(), 32'd0);
    chk("R12", {30'd0, tx_slot, tx_oe}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule